// File: doc/BRIEF.md
# Near-End Loopback Enable/Disable Sequencer

This controller-side block drives the handshake that places a PHY's digital datapath into near-end loopback and later releases it. The link state machine first reports that the Loopback state has been negotiated. A start request then makes the sequencer check the requested loop-back point against the PHY interface style. It then issues a register write to the PHY's loopback control register with the enable bit set and the chosen point, and waits for the PHY to acknowledge before it declares loopback active.

Leaving loopback is the mirror image. An explicit stop request starts it, and so does the link state machine dropping out of Loopback while the block is active. The sequencer writes the same register with the enable bit cleared, waits for the acknowledgment, and then pulses a completion flag that hands the lane back to normal operation. Each acknowledgment wait is bounded by a programmable cycle limit. A point that the interface style does not offer is refused at the start, with no register write.

Top module: `nelb_seq`

## Requirements
- R1: A start request takes effect only while the sequencer is idle and `ltssmLoop` is high. A start at any other time produces no register write and does not change `loopActive`.
- R2: An accepted start issues a write with `regWrEnable`=1 and `regWrPath` equal to `pathSel` as it was at the start. `regWrValid`, `regWrEnable` and `regWrPath` hold steady until a cycle in which `regWrReady` is high.
- R3: The point code is the 3-bit value n for loop-back point n. With `serdesMode`=0, codes 0 to 5 are legal. With `serdesMode`=1, only codes 0, 3, 4 and 5 are legal. Codes 6 and 7 are never legal. An illegal start gives a one-cycle `errPath` pulse and no write.
- R4: `loopActive` rises only in the cycle after `phyAck` is seen while waiting for the enable acknowledgment. It stays high exactly while the loopback state is held.
- R5: A `stopReq` while active issues a write with `regWrEnable`=0 and `regWrPath` equal to the point latched at the start, even if `pathSel` has changed since.
- R6: If `ltssmLoop` falls while active, the same disable write starts without any `stopReq`.
- R7: `phyAck` seen while waiting for the disable acknowledgment returns the block to idle, with a one-cycle `exitDone` pulse and `loopActive` low.
- R8: In either acknowledgment wait, an acknowledgment in wait cycle k (counted from 0 after the write is accepted) is honoured for k <= `ackLimit`. With no acknowledgment by wait cycle `ackLimit`, the block returns to idle with a one-cycle `errTimeout` pulse.
- R9: After synchronous reset (`rstN` low at a clock edge), all outputs are low and the block is idle.
- R10: `phyAck` outside the two acknowledgment waits, including a late acknowledgment after a timeout, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| serdesMode | input | 1 | Static interface style: 0 parallel PHY interface, 1 serializer interface |
| ackLimit | input | TO_W | Last wait cycle in which an acknowledgment is still honoured |
| ltssmLoop | input | 1 | Link state machine is in the Loopback state |
| startReq | input | 1 | Request to enter near-end loopback |
| stopReq | input | 1 | Request to leave near-end loopback |
| pathSel | input | 3 | Requested loop-back point code |
| regWrValid | output | 1 | Control register write request |
| regWrEnable | output | 1 | Enable bit carried by the write |
| regWrPath | output | 3 | Loop-back point carried by the write |
| regWrReady | input | 1 | One-cycle pulse: PHY accepts the write |
| phyAck | input | 1 | PHY acknowledgment of the last loopback control change |
| loopActive | output | 1 | Loopback training and traffic may proceed |
| exitDone | output | 1 | One-cycle pulse: normal operation may resume |
| errPath | output | 1 | One-cycle pulse: refused loop-back point |
| errTimeout | output | 1 | One-cycle pulse: acknowledgment wait expired |

## Verification
The hardest corner to reach is the edge of the acknowledgment window. An acknowledgment landing exactly in wait cycle `ackLimit` must win, one cycle later it must be a timeout, and the stray acknowledgment that follows must be ignored. The stimulus places the acknowledgment at a chosen distance after the accepted write, counted in clock cycles. It steps that distance to exactly the limit and to one past it, and also runs with a limit of zero, in both the enable wait and the disable wait. Exit through a falling `ltssmLoop` and a `pathSel` changed while active show that the disable write reuses the latched point.

// File: rtl/nelb_pkg.sv
`timescale 1ns/1ps
package nelb_pkg;
  localparam int PATH_W = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_EN, S_WAIT_EN, S_ACTIVE, S_WR_DIS, S_WAIT_DIS
  } seqState_t;

  typedef struct packed {
    logic latchPath;
    logic cntClr;
    logic cntRun;
    logic flagPathErr;
    logic flagTimeout;
    logic flagDone;
  } seqStrobe_t;

  function automatic logic pathLegal(input logic [PATH_W-1:0] p, input logic serdes);
    logic ok;
    if (serdes) ok = (p == PATH_W'(0)) || (p == PATH_W'(3)) || (p == PATH_W'(4)) || (p == PATH_W'(5));
    else        ok = (p <= PATH_W'(5));
    return ok;
  endfunction
endpackage

// File: rtl/nelb_fsm.sv
`timescale 1ns/1ps
module nelb_fsm
  import nelb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ltssmLoop,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       pathOk,
  input  logic       cntExpired,
  input  logic       regWrReady,
  input  logic       phyAck,
  output seqStrobe_t strb,
  output logic       regWrValid,
  output logic       regWrEnable,
  output logic       loopActive
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      S_IDLE: begin
        if (startReq && ltssmLoop) begin
          if (pathOk) begin
            nextState      = S_WR_EN;
            strb.latchPath = 1'b1;
          end else begin
            strb.flagPathErr = 1'b1;
          end
        end
      end
      S_WR_EN: begin
        if (regWrReady) begin
          nextState   = S_WAIT_EN;
          strb.cntClr = 1'b1;
        end
      end
      S_WAIT_EN: begin
        strb.cntRun = 1'b1;
        if (phyAck) begin
          nextState = S_ACTIVE;
        end else if (cntExpired) begin
          nextState        = S_IDLE;
          strb.flagTimeout = 1'b1;
        end
      end
      S_ACTIVE: begin
        if (stopReq || !ltssmLoop) nextState = S_WR_DIS;
      end
      S_WR_DIS: begin
        if (regWrReady) begin
          nextState   = S_WAIT_DIS;
          strb.cntClr = 1'b1;
        end
      end
      S_WAIT_DIS: begin
        strb.cntRun = 1'b1;
        if (phyAck) begin
          nextState     = S_IDLE;
          strb.flagDone = 1'b1;
        end else if (cntExpired) begin
          nextState        = S_IDLE;
          strb.flagTimeout = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign regWrValid  = (state == S_WR_EN) || (state == S_WR_DIS);
  assign regWrEnable = (state == S_WR_EN);
  assign loopActive  = (state == S_ACTIVE);

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regWrValid) && regWrEnable |-> $past(ltssmLoop) && $past(startReq)); // R1
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid && !regWrReady |=> regWrValid && $stable(regWrEnable)); // R2
  AST_ACT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopActive) |-> $past(phyAck)); // R4
  AST_DIS_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    loopActive && !ltssmLoop |=> regWrValid && !regWrEnable); // R6
endmodule

// File: rtl/nelb_dp.sv
`timescale 1ns/1ps
module nelb_dp
  import nelb_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              serdesMode,
  input  logic [TO_W-1:0]   ackLimit,
  input  logic [PATH_W-1:0] pathSel,
  output logic              pathOk,
  output logic              cntExpired,
  output logic [PATH_W-1:0] pathReg,
  output logic              exitDone,
  output logic              errPath,
  output logic              errTimeout
);
  logic [TO_W-1:0] cnt;

  assign pathOk     = pathLegal(pathSel, serdesMode);
  assign cntExpired = (cnt >= ackLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pathReg <= '0;
    end else if (strb.latchPath) begin
      pathReg <= pathSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.cntClr) begin
      cnt <= '0;
    end else if (strb.cntRun && !cntExpired) begin
      cnt <= cnt + TO_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exitDone   <= 1'b0;
      errPath    <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      exitDone   <= strb.flagDone;
      errPath    <= strb.flagPathErr;
      errTimeout <= strb.flagTimeout;
    end
  end

  AST_TO_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagTimeout |-> cnt >= ackLimit); // R8
  AST_PATH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchPath |=> $stable(pathReg)); // R5
endmodule

// File: rtl/nelb_seq.sv
`timescale 1ns/1ps
module nelb_seq
  import nelb_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serdesMode,
  input  logic [TO_W-1:0]   ackLimit,
  input  logic              ltssmLoop,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic [PATH_W-1:0] pathSel,
  output logic              regWrValid,
  output logic              regWrEnable,
  output logic [PATH_W-1:0] regWrPath,
  input  logic              regWrReady,
  input  logic              phyAck,
  output logic              loopActive,
  output logic              exitDone,
  output logic              errPath,
  output logic              errTimeout
);
  seqStrobe_t strb;
  logic       pathOk;
  logic       cntExpired;

  nelb_fsm i_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .ltssmLoop  (ltssmLoop),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .pathOk     (pathOk),
    .cntExpired (cntExpired),
    .regWrReady (regWrReady),
    .phyAck     (phyAck),
    .strb       (strb),
    .regWrValid (regWrValid),
    .regWrEnable(regWrEnable),
    .loopActive (loopActive)
  );

  nelb_dp #(.TO_W(TO_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .serdesMode (serdesMode),
    .ackLimit   (ackLimit),
    .pathSel    (pathSel),
    .pathOk     (pathOk),
    .cntExpired (cntExpired),
    .pathReg    (regWrPath),
    .exitDone   (exitDone),
    .errPath    (errPath),
    .errTimeout (errTimeout)
  );

  AST_REFUSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    errPath |-> !regWrValid && !loopActive); // R3
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    exitDone |-> $past(phyAck) && !loopActive); // R7
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({exitDone, errPath, errTimeout})); // R10
endmodule

// File: tb/test_nelb_seq.sv
`timescale 1ns/1ps
module test_nelb_seq;
  localparam int TO_W = 16;
  localparam int K_WR = 1, K_ACT = 2, K_DONE = 3, K_EPATH = 4, K_ETO = 5;

  typedef struct {
    int    kind;
    int    en;
    int    path;
    string req;
  } expItem_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            serdesMode = 1'b0;
  logic [TO_W-1:0] ackLimit = TO_W'(4);
  logic            ltssmLoop = 1'b1;
  logic            startReq = 1'b0;
  logic            stopReq = 1'b0;
  logic [2:0]      pathSel = 3'd0;
  logic            regWrValid, regWrEnable;
  logic [2:0]      regWrPath;
  logic            regWrReady = 1'b0;
  logic            phyAck = 1'b0;
  logic            loopActive, exitDone, errPath, errTimeout;

  int       checks = 0;
  int       failures = 0;
  int       curLimit = 4;
  bit       finished = 0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  nelb_seq #(.TO_W(TO_W)) i_nelb_seq (
    .clk(clk), .rstN(rstN), .serdesMode(serdesMode), .ackLimit(ackLimit),
    .ltssmLoop(ltssmLoop), .startReq(startReq), .stopReq(stopReq), .pathSel(pathSel),
    .regWrValid(regWrValid), .regWrEnable(regWrEnable), .regWrPath(regWrPath),
    .regWrReady(regWrReady), .phyAck(phyAck), .loopActive(loopActive),
    .exitDone(exitDone), .errPath(errPath), .errTimeout(errTimeout)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushExp(int kind, int en, int path, string req);
    expItem_t it;
    it.kind = kind; it.en = en; it.path = path; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic popCheck(int kind, int en, int path);
    expItem_t it;
    checks++;
    if (expQ.size() == 0) begin
      failures++;
      $display("FAIL R10 unexpected event: got kind %0d en %0d path %0d expected none", kind, en, path);
    end else begin
      it = expQ.pop_front();
      if (it.kind != kind || it.en != en || it.path != path) begin
        failures++;
        $display("FAIL %s event: got kind %0d en %0d path %0d expected kind %0d en %0d path %0d",
                 it.req, kind, en, path, it.kind, it.en, it.path);
      end
    end
  endtask

  // Monitor: samples 1 ns after each falling edge, ahead of the next rising edge.
  initial begin
    bit prevAct;
    prevAct = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (!rstN) begin
        prevAct = 1'b0;
      end else begin
        if (regWrValid && regWrReady) popCheck(K_WR, int'(regWrEnable), int'(regWrPath));
        if (loopActive && !prevAct)   popCheck(K_ACT, 0, 0);
        if (exitDone)                 popCheck(K_DONE, 0, 0);
        if (errPath)                  popCheck(K_EPATH, 0, 0);
        if (errTimeout)               popCheck(K_ETO, 0, 0);
        prevAct = loopActive;
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
  endtask

  task automatic serveWrite(int rdyDelay, int expEn, int expPath, string req);
    check(req, "write valid", int'(regWrValid), 1);
    check(req, "write enable bit", int'(regWrEnable), expEn);
    check(req, "write point", int'(regWrPath), expPath);
    for (int i = 0; i < rdyDelay; i++) begin
      tick();
      check("R2", "write held", int'({regWrValid, regWrEnable, regWrPath}), (1 << 4) | (expEn << 3) | expPath);
    end
    regWrReady = 1'b1;
    tick();
    regWrReady = 1'b0;
  endtask

  task automatic serveAck(int delay, bit watchActive);
    for (int i = 0; i < delay; i++) begin
      if (watchActive) check("R4", "active before ack", int'(loopActive), 0);
      tick();
    end
    phyAck = 1'b1;
    tick();
    phyAck = 1'b0;
  endtask

  task automatic enterSeq(int path, int rdyDelay, int ackDelay);
    bit ok;
    ok = (ackDelay <= curLimit);
    pushExp(K_WR, 1, path, "R2");
    pushExp(ok ? K_ACT : K_ETO, 0, 0, ok ? "R4" : "R8");
    pathSel = 3'(path);
    pulseStart();
    serveWrite(rdyDelay, 1, path, "R2");
    serveAck(ackDelay, 1'b1);
    tick();
    check(ok ? "R4" : "R10", "active after enable wait", int'(loopActive), ok ? 1 : 0);
  endtask

  task automatic exitSeq(bit viaStop, int path, int ackDelay);
    bit ok;
    ok = (ackDelay <= curLimit);
    pushExp(K_WR, 0, path, viaStop ? "R5" : "R6");
    pushExp(ok ? K_DONE : K_ETO, 0, 0, ok ? "R7" : "R8");
    if (viaStop) begin
      stopReq = 1'b1;
      tick();
      stopReq = 1'b0;
    end else begin
      ltssmLoop = 1'b0;
      tick();
    end
    serveWrite(0, 0, path, viaStop ? "R5" : "R6");
    serveAck(ackDelay, 1'b0);
    tick();
    check("R7", "active after exit", int'(loopActive), 0);
    ltssmLoop = 1'b1;
  endtask

  task automatic refuse(int path, string req);
    pushExp(K_EPATH, 0, 0, req);
    pathSel = 3'(path);
    pulseStart();
    check(req, "no write on refused point", int'(regWrValid), 0);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    check("R9", "outputs in reset",
          int'({regWrValid, regWrEnable, loopActive, exitDone, errPath, errTimeout}), 0);
    rstN = 1'b1;
    tick();
    check("R9", "outputs after reset",
          int'({regWrValid, regWrEnable, regWrPath, loopActive, exitDone, errPath, errTimeout}), 0);

    // R1: start outside Loopback is ignored
    ltssmLoop = 1'b0;
    pathSel = 3'd2;
    pulseStart();
    tick();
    check("R1", "no write without loopback", int'(regWrValid), 0);
    ltssmLoop = 1'b1;

    // R10: stray ack while idle
    phyAck = 1'b1; tick(); phyAck = 1'b0; tick();
    check("R10", "idle ack ignored", int'(loopActive), 0);

    // Parallel interface, point 2, slow ready, normal exit with changed pathSel
    enterSeq(2, 3, 1);
    pathSel = 3'd4;
    pulseStart();
    check("R1", "start while active ignored", int'({regWrValid, loopActive}), 1);
    exitSeq(1'b1, 2, 0);

    // R8 boundary: ack in the last honoured cycle, exit on loopback drop (R6)
    enterSeq(5, 0, curLimit);
    exitSeq(1'b0, 5, 2);

    // R3 refused points on the parallel interface
    refuse(6, "R3");
    refuse(7, "R3");

    // R8: one cycle late, then the late ack must be ignored (R10)
    enterSeq(1, 1, curLimit + 1);
    repeat (2) tick();
    check("R10", "late ack ignored", int'({regWrValid, loopActive}), 0);

    // Serializer interface
    serdesMode = 1'b1;
    refuse(1, "R3");
    refuse(2, "R3");
    enterSeq(3, 0, 0);
    exitSeq(1'b1, 3, 1);
    enterSeq(0, 2, 2);
    // R8: disable wait expires, ack arrives afterwards
    exitSeq(1'b1, 0, curLimit + 1);
    repeat (2) tick();
    check("R10", "idle after disable timeout", int'({regWrValid, loopActive}), 0);

    // R8 with a zero limit: only wait cycle 0 is honoured
    serdesMode = 1'b0;
    curLimit = 0;
    ackLimit = TO_W'(0);
    enterSeq(4, 0, 0);
    exitSeq(1'b1, 4, 1);
    enterSeq(0, 0, 1);

    repeat (4) tick();
    check("R2", "all expected events seen", expQ.size(), 0);
    finishRun();
  end
endmodule